// File: doc/BRIEF.md
# Interruption State Capture Unit

When a processor takes an interruption, this block records two 64-bit words that a handler later reads: a saved instruction pointer and a status word that describes the event. The pipeline raises a one-cycle event strobe. With the strobe it presents the event kind, the current and next bundle pointers, the slot indices, the access-kind flags, the translation attributes, the mode flags and the collection-enable state. Both words are captured on the clock edge that samples the strobe. They hold at all other times.

The saved pointer depends on the event kind. A fault saves the address of the faulting instruction. A trap or an external interrupt saves the address of the next instruction. In legacy-instruction-set mode the pointer is a byte address, and it is zero-extended. The status word packs the cause code, the legacy vector, the access flags, the slot and several qualifier bits. Mode-dependent fields are cleared, and the reserved bits read as zero. When collection is disabled, the status word is still written and marks the event as nested, while the saved pointer keeps its old value.

Top module: `irq_state_capture`

## Requirements
- R1: While rst_ni is low, iip_o and isr_o are both zero.
- R2: Both outputs change only on the rising clock edge that samples evt_valid_i high. In every other cycle they hold their value.
- R3: iip_o is loaded only when collect_en_i is 1 at the event. When collect_en_i is 0, iip_o keeps its previous value.
- R4: evt_kind_i encodes 2'b00 as fault, 2'b01 as trap, 2'b10 as external interrupt and 2'b11 as external interrupt. A fault saves cur_ip_i. Every other kind saves next_ip_i.
- R5: When legacy_i is 1, the saved pointer is bits 31:0 of the selected pointer, with bits 63:32 zero.
- R6: isr_o layout: bits 15:0 hold the cause code, bits 23:16 the legacy vector, bit 32 fetch, bit 33 write, bit 34 read, bit 35 non-access, bit 36 speculative, bit 37 register-stack, bit 38 incomplete frame, bit 39 nested, bit 40 supervisor override, bits 42:41 the slot and bit 43 deferral. Bits 31:24 and 63:44 are always zero.
- R7: When rmw_i is 1, both the read bit (34) and the write bit (33) are set.
- R8: For faults and external interrupts, the slot field equals restart_slot_i. For traps, it equals exc_slot_i, or 2 when long_imm_i is 1.
- R9: The deferral bit equals xlat_defer_i. It is 0 if xlat_hit_i is 0, if xlat_on_i is 0, or if rstk_i is 1.
- R10: The nested bit is set when collect_en_i is 0 or collect_chg_i is 1.
- R11: When legacy_i is 1, bits 35 to 39 and 41 to 43 are 0. When legacy_i is 0, bit 40 is 0.
- R12: An event that arrives while collect_en_i is 0 still writes isr_o, and in native mode the nested bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Interruption taken this cycle |
| evt_kind_i | input | 2 | Event kind (fault, trap, external) |
| cur_ip_i | input | 64 | Pointer of the current instruction |
| next_ip_i | input | 64 | Pointer of the next instruction |
| restart_slot_i | input | 2 | Current restart slot index |
| exc_slot_i | input | 2 | Slot of the excepting instruction (traps) |
| long_imm_i | input | 1 | Trap on a two-slot long-immediate instruction |
| acc_fetch_i | input | 1 | Event tied to an instruction fetch |
| acc_read_i | input | 1 | Event tied to a read |
| acc_write_i | input | 1 | Event tied to a write |
| rmw_i | input | 1 | Read-modify-write access |
| non_access_i | input | 1 | Non-access instruction |
| spec_i | input | 1 | Speculative load |
| rstk_i | input | 1 | Mandatory register-stack fill or spill |
| incomplete_i | input | 1 | Register frame incomplete |
| cause_i | input | 16 | Cause code |
| vector_i | input | 8 | Legacy vector number |
| xlat_hit_i | input | 1 | A translation exists for the instruction page |
| xlat_on_i | input | 1 | Instruction translation enabled |
| xlat_defer_i | input | 1 | Deferral bit of the translation |
| legacy_i | input | 1 | Legacy instruction set active |
| sup_ovr_i | input | 1 | Legacy supervisor-override condition |
| collect_en_i | input | 1 | Collection enabled |
| collect_chg_i | input | 1 | Collection enable in flight |
| iip_o | output | 64 | Saved instruction pointer |
| isr_o | output | 64 | Interruption status word |

## Verification
Each result is due on the first rising edge after the cycle in which the event is presented. There is one register stage and no other latency, so iip_o and isr_o reflect an event one edge later. The bench drives inputs on falling edges. A behavioural model updates its expected words on the rising edge from the same sampled inputs. On every falling edge the outputs are compared field by field against the model, and this also covers the hold behaviour in cycles with no event.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned CODE_W = 16;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned SLOT_W = 2;

  typedef enum logic [1:0] {
    EVT_FAULT = 2'b00,
    EVT_TRAP  = 2'b01,
    EVT_EXT   = 2'b10,
    EVT_EXT2  = 2'b11
  } evt_kind_e;

  // MSB first; positions are read by handler software
  typedef struct packed {
    logic [19:0]       rsv_hi;
    logic              defer;
    logic [SLOT_W-1:0] slot;
    logic              sup_ovr;
    logic              nested;
    logic              incomplete;
    logic              rstk;
    logic              spec;
    logic              non_access;
    logic              rd;
    logic              wr;
    logic              fetch;
    logic [7:0]        rsv_mid;
    logic [VEC_W-1:0]  vector;
    logic [CODE_W-1:0] cause;
  } isr_t;

  localparam logic [SLOT_W-1:0] LONG_IMM_SLOT = SLOT_W'(2);
endpackage

// File: rtl/irq_ptr_sel.sv
module irq_ptr_sel #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned LEG_AW = 32
) (
  input  logic [1:0]      kind_i,
  input  logic            legacy_i,
  input  logic [XLEN-1:0] cur_ip_i,
  input  logic [XLEN-1:0] next_ip_i,
  output logic [XLEN-1:0] ptr_o
);
  import irq_cap_pkg::*;

  logic [XLEN-1:0] sel;

  always_comb begin
    if (evt_kind_e'(kind_i) == EVT_FAULT) sel = cur_ip_i;
    else                                  sel = next_ip_i;
  end

  generate
    if (LEG_AW < XLEN) begin : g_ext
      always_comb begin
        ptr_o = sel;
        if (legacy_i) ptr_o = {{(XLEN-LEG_AW){1'b0}}, sel[LEG_AW-1:0]};
      end
    end else begin : g_full
      logic unused_leg;
      assign unused_leg = legacy_i;
      assign ptr_o = sel;
    end
  endgenerate
endmodule

// File: rtl/irq_slot_sel.sv
module irq_slot_sel (
  input  logic [1:0]                  kind_i,
  input  logic [irq_cap_pkg::SLOT_W-1:0] restart_slot_i,
  input  logic [irq_cap_pkg::SLOT_W-1:0] exc_slot_i,
  input  logic                        long_imm_i,
  output logic [irq_cap_pkg::SLOT_W-1:0] slot_o
);
  import irq_cap_pkg::*;

  always_comb begin
    unique case (evt_kind_e'(kind_i))
      EVT_TRAP: slot_o = long_imm_i ? LONG_IMM_SLOT : exc_slot_i;
      default:  slot_o = restart_slot_i;
    endcase
  end
endmodule

// File: rtl/irq_status_build.sv
module irq_status_build (
  input  logic [1:0]                    kind_i,
  input  logic [irq_cap_pkg::SLOT_W-1:0] restart_slot_i,
  input  logic [irq_cap_pkg::SLOT_W-1:0] exc_slot_i,
  input  logic                          long_imm_i,
  input  logic                          acc_fetch_i,
  input  logic                          acc_read_i,
  input  logic                          acc_write_i,
  input  logic                          rmw_i,
  input  logic                          non_access_i,
  input  logic                          spec_i,
  input  logic                          rstk_i,
  input  logic                          incomplete_i,
  input  logic [irq_cap_pkg::CODE_W-1:0] cause_i,
  input  logic [irq_cap_pkg::VEC_W-1:0]  vector_i,
  input  logic                          xlat_hit_i,
  input  logic                          xlat_on_i,
  input  logic                          xlat_defer_i,
  input  logic                          legacy_i,
  input  logic                          sup_ovr_i,
  input  logic                          collect_en_i,
  input  logic                          collect_chg_i,
  output irq_cap_pkg::isr_t             isr_o
);
  import irq_cap_pkg::*;

  logic [SLOT_W-1:0] slot;
  logic              native;

  assign native = ~legacy_i;

  irq_slot_sel u_slot (
    .kind_i         (kind_i),
    .restart_slot_i (restart_slot_i),
    .exc_slot_i     (exc_slot_i),
    .long_imm_i     (long_imm_i),
    .slot_o         (slot)
  );

  always_comb begin
    isr_o            = '0;
    isr_o.cause      = cause_i;
    isr_o.vector     = vector_i;
    isr_o.fetch      = acc_fetch_i;
    isr_o.wr         = acc_write_i | rmw_i;
    isr_o.rd         = acc_read_i | rmw_i;
    // native-only qualifiers
    isr_o.non_access = native & non_access_i;
    isr_o.spec       = native & spec_i;
    isr_o.rstk       = native & rstk_i;
    isr_o.incomplete = native & incomplete_i;
    isr_o.nested     = native & (~collect_en_i | collect_chg_i);
    isr_o.slot       = native ? slot : '0;
    isr_o.defer      = native & xlat_hit_i & xlat_on_i & ~rstk_i & xlat_defer_i;
    // legacy-only qualifier
    isr_o.sup_ovr    = legacy_i & sup_ovr_i;
  end
endmodule

// File: rtl/irq_state_capture.sv
module irq_state_capture #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned LEG_AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_valid_i,
  input  logic [1:0]      evt_kind_i,
  input  logic [XLEN-1:0] cur_ip_i,
  input  logic [XLEN-1:0] next_ip_i,
  input  logic [1:0]      restart_slot_i,
  input  logic [1:0]      exc_slot_i,
  input  logic            long_imm_i,
  input  logic            acc_fetch_i,
  input  logic            acc_read_i,
  input  logic            acc_write_i,
  input  logic            rmw_i,
  input  logic            non_access_i,
  input  logic            spec_i,
  input  logic            rstk_i,
  input  logic            incomplete_i,
  input  logic [15:0]     cause_i,
  input  logic [7:0]      vector_i,
  input  logic            xlat_hit_i,
  input  logic            xlat_on_i,
  input  logic            xlat_defer_i,
  input  logic            legacy_i,
  input  logic            sup_ovr_i,
  input  logic            collect_en_i,
  input  logic            collect_chg_i,
  output logic [63:0]     iip_o,
  output logic [63:0]     isr_o
);
  import irq_cap_pkg::*;

  logic [XLEN-1:0] ptr_d;
  isr_t            isr_d;
  logic [XLEN-1:0] iip_q;
  isr_t            isr_q;

  irq_ptr_sel #(.XLEN(XLEN), .LEG_AW(LEG_AW)) u_ptr (
    .kind_i    (evt_kind_i),
    .legacy_i  (legacy_i),
    .cur_ip_i  (cur_ip_i),
    .next_ip_i (next_ip_i),
    .ptr_o     (ptr_d)
  );

  irq_status_build u_isr (
    .kind_i         (evt_kind_i),
    .restart_slot_i (restart_slot_i),
    .exc_slot_i     (exc_slot_i),
    .long_imm_i     (long_imm_i),
    .acc_fetch_i    (acc_fetch_i),
    .acc_read_i     (acc_read_i),
    .acc_write_i    (acc_write_i),
    .rmw_i          (rmw_i),
    .non_access_i   (non_access_i),
    .spec_i         (spec_i),
    .rstk_i         (rstk_i),
    .incomplete_i   (incomplete_i),
    .cause_i        (cause_i),
    .vector_i       (vector_i),
    .xlat_hit_i     (xlat_hit_i),
    .xlat_on_i      (xlat_on_i),
    .xlat_defer_i   (xlat_defer_i),
    .legacy_i       (legacy_i),
    .sup_ovr_i      (sup_ovr_i),
    .collect_en_i   (collect_en_i),
    .collect_chg_i  (collect_chg_i),
    .isr_o          (isr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iip_q <= '0;
      isr_q <= '0;
    end else if (evt_valid_i) begin
      isr_q <= isr_d;
      if (collect_en_i) iip_q <= ptr_d;
    end
  end

  assign iip_o = 64'(iip_q);
  assign isr_o = isr_q;
endmodule

// File: rtl/irq_cap_chk.sv
module irq_cap_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        evt_valid_i,
  input logic [1:0]  evt_kind_i,
  input logic [63:0] cur_ip_i,
  input logic        rmw_i,
  input logic        legacy_i,
  input logic        collect_en_i,
  input logic [63:0] iip_o,
  input logic [63:0] isr_o
);
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni -> (iip_o == 64'd0 && isr_o == 64'd0)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> ($stable(iip_o) && $stable(isr_o)));

  p_no_collect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !collect_en_i) |=> $stable(iip_o));

  p_fault_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && collect_en_i && !legacy_i && evt_kind_i == 2'b00)
      |=> (iip_o == $past(cur_ip_i)));

  p_legacy_ptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && collect_en_i && legacy_i) |=> (iip_o[63:32] == 32'd0));

  p_reserved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_o[31:24] == 8'd0 && isr_o[63:44] == 20'd0));

  p_rmw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && rmw_i) |=> (isr_o[34] && isr_o[33]));

  p_legacy_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && legacy_i) |=> (isr_o[39:35] == 5'd0 && isr_o[43:41] == 3'd0));

  p_native_so_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !legacy_i) |=> !isr_o[40]);

  p_nested_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !collect_en_i && !legacy_i) |=> isr_o[39]);
endmodule

bind irq_state_capture irq_cap_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_valid_i  (evt_valid_i),
  .evt_kind_i   (evt_kind_i),
  .cur_ip_i     (cur_ip_i),
  .rmw_i        (rmw_i),
  .legacy_i     (legacy_i),
  .collect_en_i (collect_en_i),
  .iip_o        (iip_o),
  .isr_o        (isr_o)
);

// File: tb/sim_irq_state_capture.sv
`timescale 1ns/1ps
module sim_irq_state_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev = 0;
  logic [1:0]  kind = 0;
  logic [63:0] cip = 0, nip = 0;
  logic [1:0]  rslot = 0, xslot = 0;
  logic        limm = 0, f = 0, r = 0, w = 0, rmw = 0, nacc = 0, spec = 0;
  logic        rstk = 0, inc = 0, tv = 0, ton = 0, tdef = 0, leg = 0, so = 0;
  logic        cen = 0, cchg = 0;
  logic [15:0] cause = 0;
  logic [7:0]  vec = 0;
  logic [63:0] iip, isr;

  int n_cmp = 0, n_bad = 0;
  logic [63:0] e_iip = 0, e_isr = 0;
  logic [63:0] s;
  logic [63:0] p;

  always #5 clk = ~clk;

  irq_state_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(ev), .evt_kind_i(kind),
    .cur_ip_i(cip), .next_ip_i(nip), .restart_slot_i(rslot), .exc_slot_i(xslot),
    .long_imm_i(limm), .acc_fetch_i(f), .acc_read_i(r), .acc_write_i(w),
    .rmw_i(rmw), .non_access_i(nacc), .spec_i(spec), .rstk_i(rstk),
    .incomplete_i(inc), .cause_i(cause), .vector_i(vec), .xlat_hit_i(tv),
    .xlat_on_i(ton), .xlat_defer_i(tdef), .legacy_i(leg), .sup_ovr_i(so),
    .collect_en_i(cen), .collect_chg_i(cchg), .iip_o(iip), .isr_o(isr)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_iip = 0;
      e_isr = 0;
    end else if (ev) begin
      s = 0;
      s[15:0]  = cause;
      s[23:16] = vec;
      s[32] = f;
      s[33] = w || rmw;
      s[34] = r || rmw;
      if (!leg) begin
        s[35] = nacc; s[36] = spec; s[37] = rstk; s[38] = inc;
        s[39] = !cen || cchg;
        if (kind == 2'b01) s[42:41] = limm ? 2'd2 : xslot;
        else               s[42:41] = rslot;
        s[43] = tdef && tv && ton && !rstk;
      end else begin
        s[40] = so;
      end
      e_isr = s;
      if (cen) begin
        p = (kind == 2'b00) ? cip : nip;
        e_iip = leg ? {32'd0, p[31:0]} : p;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, a, e, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 R3 R4 R5 iip", iip, e_iip);
    chk("R6 cause/vector", {48'd0, isr[23:0]}, {48'd0, e_isr[23:0]});
    chk("R6 reserved", {isr[63:44], isr[31:24]}, 28'd0);
    chk("R6 R7 access", {61'd0, isr[34:32]}, {61'd0, e_isr[34:32]});
    chk("R11 native qualifiers", {60'd0, isr[38:35]}, {60'd0, e_isr[38:35]});
    chk("R10 R12 nested", {63'd0, isr[39]}, {63'd0, e_isr[39]});
    chk("R11 supervisor override", {63'd0, isr[40]}, {63'd0, e_isr[40]});
    chk("R8 slot", {62'd0, isr[42:41]}, {62'd0, e_isr[42:41]});
    chk("R9 deferral", {63'd0, isr[43]}, {63'd0, e_isr[43]});
  end

  task automatic clear_in();
    ev = 0; kind = 0; limm = 0; f = 0; r = 0; w = 0; rmw = 0; nacc = 0;
    spec = 0; rstk = 0; inc = 0; tv = 0; ton = 0; tdef = 0; leg = 0; so = 0;
    cen = 1; cchg = 0;
  endtask

  task automatic rand_in();
    ev = ($urandom_range(0, 1) == 1);
    kind = 2'($urandom); cip = {$urandom, $urandom}; nip = {$urandom, $urandom};
    rslot = 2'($urandom_range(0, 2)); xslot = 2'($urandom_range(0, 2));
    {limm, f, r, w, rmw, nacc, spec, rstk} = 8'($urandom);
    {inc, tv, ton, tdef, leg, so, cchg} = 7'($urandom);
    cen = ($urandom_range(0, 3) != 0);
    cause = 16'($urandom); vec = 8'($urandom);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_in();
    cip = 64'hFFFF_0000_1234_5670; nip = 64'hFFFF_0000_1234_5680;
    cause = 16'hBEEF; vec = 8'd13;
    ev = 1;
    step();
    step();
    // R1: reset holds outputs at zero even with an event pending
    chk("R1 iip reset", iip, 64'd0);
    chk("R1 isr reset", isr, 64'd0);
    ev = 0;
    rst_n = 1;
    step();
    // R4 fault, native
    ev = 1; kind = 2'b00; rslot = 2'd1; f = 1; tv = 1; ton = 1; tdef = 1; step();
    ev = 0; step();
    // R8 trap on long-immediate, R9 deferral suppressed by rstk
    ev = 1; kind = 2'b01; xslot = 2'd0; limm = 1; rstk = 1; tdef = 1; step();
    // R4 external, R7 rmw
    ev = 1; kind = 2'b10; limm = 0; rstk = 0; rmw = 1; rslot = 2'd2; step();
    // R5 legacy with supervisor override and native-only inputs set
    clear_in(); ev = 1; kind = 2'b01; leg = 1; so = 1; nacc = 1; spec = 1;
    inc = 1; xslot = 2'd2; cip = 64'hDEAD_BEEF_0000_0010; nip = 64'hDEAD_BEEF_0000_0014; step();
    // R3 R12 collection disabled
    clear_in(); ev = 1; cen = 0; kind = 2'b00; cip = 64'h1; step();
    // R10 collection in flight
    clear_in(); ev = 1; cchg = 1; kind = 2'b11; nip = 64'h2222; step();
    // R9 no translation / translation off
    clear_in(); ev = 1; tv = 0; ton = 1; tdef = 1; step();
    clear_in(); ev = 1; tv = 1; ton = 0; tdef = 1; step();
    clear_in(); step(); step();
    for (int i = 0; i < 3000; i++) begin
      rand_in();
      step();
    end
    clear_in();
    step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule